// File: doc/BRIEF.md
# Flow-Through Burst Synchronous SRAM

This block is a synthesizable behavioural model of a single-access burst SRAM. The word is 36 bits wide and is built from four lanes: each lane has eight data bits and one parity bit. On every rising clock edge the block captures the address, three chip selects, two start strobes, a burst-advance input and the write controls. From these it picks one of four states: idle (deselected), read, write or sleep. Read data comes straight from the array at the registered address and needs no output register, so a read word is valid in the same clock period as the edge that started it.

A burst covers four words inside an aligned four-word block. It begins with either of two start strobes. The processor-side strobe is honoured only while the primary select is low, and it always starts a read. The controller-side strobe starts a read or a write according to the write controls sampled on the same edge. After the start, the advance input either steps to the next beat or holds the current beat as a wait cycle. The beat order is linear or interleaved, chosen by a static mode input.

The data bus is modelled as split buses. There is an input word, an output word and a drive-enable output that stands in for the tri-state control of the pins. The drive enable is combinational in the asynchronous output-enable input.

The states and their transitions:

| From | To | Name | Condition |
|------|----|------|-----------|
| any | SLEEP | `enter_sleep` | sleep input high |
| any | IDLE | `deselect` | a start strobe is accepted while the selects are not all active |
| any | READ | `cpu_start` | processor strobe low, primary select low, and all selects active |
| any | READ or WRITE | `ctl_start` | controller strobe low and all selects active; WRITE if any lane is enabled |
| READ/WRITE | READ/WRITE | `continue` | no strobe accepted; the beat steps if advance is low and holds if it is high; WRITE if any lane is enabled |
| IDLE/SLEEP | IDLE | `stay_idle` | no strobe accepted and sleep low |

Top module: `fbsram_top`

## Requirements
- R1: Processor strobe low with the primary select low and all selects active loads the external address and enters READ, even if the write controls are active. The array is not written. The word at that address appears on `rdata_o` with `rdrive_o` high within the same clock period.
- R2: While the primary select is high, the processor strobe is ignored. The cycle proceeds as if that strobe were high.
- R3: Controller strobe low with all selects active loads the external address. It enters WRITE if any lane is enabled on that edge, and READ otherwise.
- R4: A strobe accepted while `sel_n_i` is high, `sel2_n_i` is high or `sel3_i` is low deselects the block. A deselected block writes nothing and holds `rdrive_o` low.
- R5: With linear mode (`lin_mode_i`=1), each advance-low edge with no accepted strobe moves to beat (start + k) mod 4 in the two address LSBs. The upper address bits are unchanged.
- R6: With interleaved mode (`lin_mode_i`=0), beat k uses the start LSBs XOR k.
- R7: With no accepted strobe, an advance-high edge keeps the current address (a wait cycle). The cycle reads or writes according to the write controls.
- R8: A write after a processor-strobe start is made by asserting the write controls on the following wait-cycle edge. That write lands at the start address.
- R9: Global write low writes all 36 bits, whatever the other write controls are.
- R10: Otherwise lane n is written only when its lane-write input and the lane gate are both low. Lane n is data bits 8n+7..8n plus bit 32+n. With the gate high, no lane is written.
- R11: `rdrive_o` equals READ state AND `oe_n_i` low. It follows `oe_n_i` without a clock, and it is never high in WRITE state.
- R12: Sleep high makes the block do no access: no write, and `rdrive_o` low. When sleep goes low, the block is idle until a start strobe arrives.
- R13: After reset the address register is zero, the state is IDLE and `rdrive_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | External word address |
| sel_n_i | input | 1 | Primary select, active low; also gates the processor strobe |
| sel2_n_i | input | 1 | Second select, active low |
| sel3_i | input | 1 | Third select, active high |
| cpu_start_n_i | input | 1 | Processor-side start strobe, active low, read only |
| ctl_start_n_i | input | 1 | Controller-side start strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low; high gives a wait cycle |
| all_wr_n_i | input | 1 | Global write, active low |
| lane_gate_n_i | input | 1 | Lane-write gate, active low |
| lane_wr_n_i | input | LANES | Per-lane write, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Standby request, active high |
| lin_mode_i | input | 1 | Burst order: 1 linear, 0 interleaved (static) |
| wdata_i | input | W | Write data (bus input side) |
| rdata_o | output | W | Read data (bus output side) |
| rdrive_o | output | 1 | Bus drive enable; low means high impedance |

## Verification
The bench covers the following corner cases:
- A processor-strobe start with the write controls held low. A design that let the strobe write would corrupt the word and float the bus.
- A processor strobe issued while the primary select is high during a burst. A design that accepted it would jump to the new address.
- Burst wrap-around in both beat orders. A wrong order shows up as the wrong word on the third or fourth beat.
- A write on the wait cycle after a processor start.
- Masked lane writes, including the parity bits and a gate-high no-op.
- Deselect and sleep edges carrying write controls. A design that leaked an access there would change the stored word.
- Output-enable changes without a clock edge. A registered output enable would lag by a cycle.

// File: rtl/fbsram_pkg.sv
`timescale 1ns/1ps
package fbsram_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RD    = 2'd1,
        ST_WR    = 2'd2,
        ST_SLEEP = 2'd3
    } st_e;

    // Two LSBs of the k-th beat for a burst that starts at 'base'.
    function automatic logic [BEAT_W-1:0] beat_ofs(
        input logic [BEAT_W-1:0] base,
        input logic [BEAT_W-1:0] cnt,
        input logic              lin
    );
        logic [BEAT_W-1:0] sum;
        sum = base + cnt;
        return lin ? sum : (base ^ cnt);
    endfunction

endpackage

// File: rtl/fbsram_wrdec.sv
`timescale 1ns/1ps
module fbsram_wrdec #(
    parameter int LANES = 4
) (
    input  logic             all_wr_n_i,
    input  logic             lane_gate_n_i,
    input  logic [LANES-1:0] lane_wr_n_i,
    output logic [LANES-1:0] lane_en_o
);

    // Global write overrides; otherwise the gate qualifies each lane.
    for (genvar n = 0; n < LANES; n++) begin : g_lane
        assign lane_en_o[n] = !all_wr_n_i || (!lane_gate_n_i && !lane_wr_n_i[n]);
    end

endmodule

// File: rtl/fbsram_array.sv
`timescale 1ns/1ps
module fbsram_array #(
    parameter  int DEPTH   = 256,
    parameter  int LANES   = 4,
    parameter  int LANE_DW = 8,
    localparam int AW      = $clog2(DEPTH),
    localparam int W       = LANES * (LANE_DW + 1),
    localparam int PAR_LSB = LANES * LANE_DW
) (
    input  logic             clk,
    input  logic [AW-1:0]    waddr_i,
    input  logic [LANES-1:0] we_i,
    input  logic [W-1:0]     wdata_i,
    input  logic [AW-1:0]    raddr_i,
    output logic [W-1:0]     rdata_o
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int n = 0; n < LANES; n++) begin
            if (we_i[n]) begin
                mem[waddr_i][n*LANE_DW +: LANE_DW] <= wdata_i[n*LANE_DW +: LANE_DW];
                mem[waddr_i][PAR_LSB + n]          <= wdata_i[PAR_LSB + n];
            end
        end
    end

    // Flow-through read: no output register.
    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/fbsram_ctrl.sv
`timescale 1ns/1ps
module fbsram_ctrl
    import fbsram_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr_i,
    input  logic             sel_n_i,
    input  logic             sel2_n_i,
    input  logic             sel3_i,
    input  logic             cpu_start_n_i,
    input  logic             ctl_start_n_i,
    input  logic             adv_n_i,
    input  logic             sleep_i,
    input  logic             lin_mode_i,
    input  logic [LANES-1:0] lane_en_i,
    output st_e              st_o,
    output logic [AW-1:0]    cur_addr_o,
    output logic [AW-1:0]    wr_addr_o,
    output logic [LANES-1:0] wr_en_o,
    output logic             rd_active_o
);

    localparam int HI_W = AW - BEAT_W;

    st_e               st_q, st_d;
    logic [HI_W-1:0]   hi_q;
    logic [BEAT_W-1:0] base_q, cnt_q;
    logic              load, step;
    logic              sel_ok, cpu_take, any_lane;
    logic [BEAT_W-1:0] cnt_nx;

    assign sel_ok   = !sel_n_i && !sel2_n_i && sel3_i;
    assign cpu_take = !cpu_start_n_i && !sel_n_i;
    assign any_lane = |lane_en_i;
    assign cnt_nx   = cnt_q + BEAT_W'(1);

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            hi_q   <= '0;
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            st_q <= st_d;
            if (load) begin
                hi_q   <= addr_i[AW-1:BEAT_W];
                base_q <= addr_i[BEAT_W-1:0];
                cnt_q  <= '0;
            end else if (step) begin
                cnt_q  <= cnt_nx;
            end
        end
    end

    // Next-state decode
    always_comb begin
        st_d = st_q;
        load = 1'b0;
        step = 1'b0;
        if (sleep_i) begin
            st_d = ST_SLEEP;                          // enter_sleep
        end else if (cpu_take) begin
            load = sel_ok;
            st_d = sel_ok ? ST_RD : ST_IDLE;          // cpu_start / deselect
        end else if (!ctl_start_n_i) begin
            load = sel_ok;
            if (!sel_ok)
                st_d = ST_IDLE;                       // deselect
            else
                st_d = any_lane ? ST_WR : ST_RD;      // ctl_start
        end else begin
            unique case (st_q)
                ST_IDLE, ST_SLEEP: st_d = ST_IDLE;    // stay_idle
                ST_RD, ST_WR: begin                   // continue
                    step = !adv_n_i;
                    st_d = any_lane ? ST_WR : ST_RD;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // Output process
    always_comb begin
        st_o        = st_q;
        rd_active_o = (st_q == ST_RD);
        cur_addr_o  = {hi_q, beat_ofs(base_q, cnt_q, lin_mode_i)};
        if (load)
            wr_addr_o = addr_i;
        else
            wr_addr_o = {hi_q, beat_ofs(base_q, step ? cnt_nx : cnt_q, lin_mode_i)};
        wr_en_o = (st_d == ST_WR) ? lane_en_i : '0;
    end

endmodule

// File: rtl/fbsram_top.sv
`timescale 1ns/1ps
module fbsram_top #(
    parameter  int DEPTH   = 256,
    parameter  int LANES   = 4,
    parameter  int LANE_DW = 8,
    localparam int AW      = $clog2(DEPTH),
    localparam int W       = LANES * (LANE_DW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr_i,
    input  logic             sel_n_i,
    input  logic             sel2_n_i,
    input  logic             sel3_i,
    input  logic             cpu_start_n_i,
    input  logic             ctl_start_n_i,
    input  logic             adv_n_i,
    input  logic             all_wr_n_i,
    input  logic             lane_gate_n_i,
    input  logic [LANES-1:0] lane_wr_n_i,
    input  logic             oe_n_i,
    input  logic             sleep_i,
    input  logic             lin_mode_i,
    input  logic [W-1:0]     wdata_i,
    output logic [W-1:0]     rdata_o,
    output logic             rdrive_o
);

    fbsram_pkg::st_e  st;
    logic [LANES-1:0] lane_en, wr_en;
    logic [AW-1:0]    cur_addr, wr_addr;
    logic             rd_active;

    fbsram_wrdec #(.LANES(LANES)) u_wrdec (
        .all_wr_n_i   (all_wr_n_i),
        .lane_gate_n_i(lane_gate_n_i),
        .lane_wr_n_i  (lane_wr_n_i),
        .lane_en_o    (lane_en)
    );

    fbsram_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_i       (addr_i),
        .sel_n_i      (sel_n_i),
        .sel2_n_i     (sel2_n_i),
        .sel3_i       (sel3_i),
        .cpu_start_n_i(cpu_start_n_i),
        .ctl_start_n_i(ctl_start_n_i),
        .adv_n_i      (adv_n_i),
        .sleep_i      (sleep_i),
        .lin_mode_i   (lin_mode_i),
        .lane_en_i    (lane_en),
        .st_o         (st),
        .cur_addr_o   (cur_addr),
        .wr_addr_o    (wr_addr),
        .wr_en_o      (wr_en),
        .rd_active_o  (rd_active)
    );

    fbsram_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_DW(LANE_DW)) u_array (
        .clk    (clk),
        .waddr_i(wr_addr),
        .we_i   (wr_en),
        .wdata_i(wdata_i),
        .raddr_i(cur_addr),
        .rdata_o(rdata_o)
    );

    // Asynchronous output enable gates the drive.
    assign rdrive_o = rd_active && !oe_n_i;

endmodule

// File: rtl/fbsram_chk.sv
`timescale 1ns/1ps
module fbsram_chk #(
    parameter int AW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   addr_i,
    input logic            sel_n_i,
    input logic            sel2_n_i,
    input logic            sel3_i,
    input logic            cpu_start_n_i,
    input logic            ctl_start_n_i,
    input logic            adv_n_i,
    input logic            all_wr_n_i,
    input logic            oe_n_i,
    input logic            sleep_i,
    input logic            lin_mode_i,
    input logic            rdrive_o,
    input fbsram_pkg::st_e st,
    input logic [AW-1:0]   cur_addr
);
    import fbsram_pkg::*;

    logic sel_ok;
    assign sel_ok = !sel_n_i && !sel2_n_i && sel3_i;

    p_reset_hiz_r13: assert property (@(posedge clk)
        !rst_n |=> !rdrive_o);

    p_cpu_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_start_n_i && sel_ok && !sleep_i) |=> (st == ST_RD));

    p_ctl_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_start_n_i && (cpu_start_n_i || sel_n_i) && sel_ok && !sleep_i)
        |=> (cur_addr == $past(addr_i)));

    p_desel_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ctl_start_n_i || (!cpu_start_n_i && !sel_n_i)) && !sel_ok && !sleep_i)
        |=> !rdrive_o);

    p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_start_n_i || sel_n_i) && ctl_start_n_i && adv_n_i && !sleep_i
         && (st == ST_RD || st == ST_WR))
        |=> ($stable(cur_addr) || !$stable(lin_mode_i)));

    p_gw_no_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_wr_n_i && cpu_start_n_i && !sleep_i) |=> !rdrive_o);

    p_sleep_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (st == ST_SLEEP && !rdrive_o));

    p_drive_needs_oe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rdrive_o |-> (!oe_n_i && st == ST_RD));

endmodule

bind fbsram_top fbsram_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_i       (addr_i),
    .sel_n_i      (sel_n_i),
    .sel2_n_i     (sel2_n_i),
    .sel3_i       (sel3_i),
    .cpu_start_n_i(cpu_start_n_i),
    .ctl_start_n_i(ctl_start_n_i),
    .adv_n_i      (adv_n_i),
    .all_wr_n_i   (all_wr_n_i),
    .oe_n_i       (oe_n_i),
    .sleep_i      (sleep_i),
    .lin_mode_i   (lin_mode_i),
    .rdrive_o     (rdrive_o),
    .st           (st),
    .cur_addr     (cur_addr)
);

// File: tb/fbsram_top_tb_top.sv
`timescale 1ns/1ps
module fbsram_top_tb_top;

    localparam int DEPTH = 256;
    localparam int AW    = 8;
    localparam int W     = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          sel_n = 1'b0, sel2_n = 1'b0, sel3 = 1'b1;
    logic          cpu_n = 1'b1, ctl_n = 1'b1, adv_n = 1'b1;
    logic          gw_n = 1'b1, gate_n = 1'b1;
    logic [3:0]    bw_n = 4'hF;
    logic          oe_n = 1'b0, sleep = 1'b0, lin = 1'b1;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  rdata;
    logic          rdrive;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    fbsram_top #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr),
        .sel_n_i(sel_n), .sel2_n_i(sel2_n), .sel3_i(sel3),
        .cpu_start_n_i(cpu_n), .ctl_start_n_i(ctl_n), .adv_n_i(adv_n),
        .all_wr_n_i(gw_n), .lane_gate_n_i(gate_n), .lane_wr_n_i(bw_n),
        .oe_n_i(oe_n), .sleep_i(sleep), .lin_mode_i(lin),
        .wdata_i(wdata), .rdata_o(rdata), .rdrive_o(rdrive)
    );

    function automatic logic [W-1:0] pat(input logic [7:0] a);
        return {a[3:0], {4{a}}} ^ 36'h5_A5C3_0000;
    endfunction

    // Lane n: bits 8n+7..8n and 32+n.
    function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] nw,
                                           input logic [3:0] m);
        logic [W-1:0] r;
        r = old;
        for (int n = 0; n < 4; n++) begin
            if (m[n]) begin
                r[n*8 +: 8] = nw[n*8 +: 8];
                r[32+n]     = nw[32+n];
            end
        end
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_read(input string tag, input logic [W-1:0] exp);
        chk({tag, " drive"}, W'(rdrive), W'(1));
        chk({tag, " data"}, rdata, exp);
    endtask

    task automatic ctl_write(input logic [7:0] a, input logic [W-1:0] d);
        addr = a; wdata = d; ctl_n = 1'b0; gw_n = 1'b0;
        tick();
        ctl_n = 1'b1; gw_n = 1'b1;
    endtask

    task automatic ctl_read(input logic [7:0] a);
        addr = a; ctl_n = 1'b0;
        tick();
        ctl_n = 1'b1;
    endtask

    task automatic t_reset();
        chk("R13 reset hiz", W'(rdrive), W'(0));
        rst_n = 1'b1;
        tick();
        chk("R13 idle after reset", W'(rdrive), W'(0));
    endtask

    task automatic t_ctl_rw();
        for (int a = 'h10; a < 'h14; a++) ctl_write(8'(a), pat(8'(a)));
        ctl_write(8'h20, pat(8'h20));
        ctl_write(8'h30, pat(8'h30));
        ctl_write(8'h40, pat(8'h40));
        ctl_write(8'h50, pat(8'h50));
        chk("R3 write cycle not driven", W'(rdrive), W'(0));
        ctl_read(8'h20);
        chk_read("R3 ctl read", pat(8'h20));
        ctl_read(8'h13);
        chk_read("R3 ctl read 2", pat(8'h13));
    endtask

    task automatic t_cpu_start();
        addr = 8'h40; cpu_n = 1'b0; gw_n = 1'b0; wdata = '1;
        tick();
        cpu_n = 1'b1; gw_n = 1'b1;
        chk_read("R1 cpu start reads same period", pat(8'h40));
        ctl_read(8'h40);
        chk_read("R1 cpu start did not write", pat(8'h40));
    endtask

    task automatic t_cpu_ignored();
        ctl_read(8'h20);
        sel_n = 1'b1; cpu_n = 1'b0; addr = 8'h30; adv_n = 1'b1;
        tick();
        sel_n = 1'b0; cpu_n = 1'b1;
        chk_read("R2 cpu strobe ignored", pat(8'h20));
    endtask

    task automatic t_cpu_then_write();
        addr = 8'h50; cpu_n = 1'b0;
        tick();
        cpu_n = 1'b1; adv_n = 1'b1; gw_n = 1'b0; wdata = 36'h9_1234_5678;
        tick();
        gw_n = 1'b1;
        chk("R8 wait write not driven", W'(rdrive), W'(0));
        ctl_read(8'h50);
        chk_read("R8 write on wait cycle", 36'h9_1234_5678);
    endtask

    task automatic t_deselect();
        addr = 8'h20; ctl_n = 1'b0; sel3 = 1'b0; gw_n = 1'b0; wdata = '0;
        tick();
        ctl_n = 1'b1; sel3 = 1'b1; gw_n = 1'b1;
        chk("R4 deselect hiz", W'(rdrive), W'(0));
        addr = 8'h20; cpu_n = 1'b0; sel2_n = 1'b1;
        tick();
        cpu_n = 1'b1; sel2_n = 1'b0;
        chk("R4 cpu deselect hiz", W'(rdrive), W'(0));
        tick();
        chk("R4 stays idle", W'(rdrive), W'(0));
        ctl_read(8'h20);
        chk_read("R4 no write when deselected", pat(8'h20));
    endtask

    task automatic t_linear();
        lin = 1'b1;
        ctl_read(8'h11);
        chk_read("R5 beat0", pat(8'h11));
        adv_n = 1'b0;
        tick(); chk_read("R5 beat1", pat(8'h12));
        tick(); chk_read("R5 beat2", pat(8'h13));
        tick(); chk_read("R5 beat3 wrap", pat(8'h10));
        tick(); chk_read("R5 wrap to start", pat(8'h11));
        adv_n = 1'b1;
    endtask

    task automatic t_interleave();
        lin = 1'b0;
        ctl_read(8'h11);
        chk_read("R6 beat0", pat(8'h11));
        adv_n = 1'b0;
        tick(); chk_read("R6 beat1", pat(8'h10));
        tick(); chk_read("R6 beat2", pat(8'h13));
        tick(); chk_read("R6 beat3", pat(8'h12));
        adv_n = 1'b1;
        ctl_read(8'h12);
        adv_n = 1'b0;
        tick(); chk_read("R6 from 2 beat1", pat(8'h13));
        adv_n = 1'b1;
        tick(); chk_read("R7 wait holds", pat(8'h13));
        adv_n = 1'b0;
        tick(); chk_read("R7 resume beat2", pat(8'h10));
        adv_n = 1'b1;
        lin = 1'b1;
    endtask

    task automatic t_lanes();
        logic [W-1:0] exp;
        exp = merge(pat(8'h30), '1, 4'b0101);
        addr = 8'h30; ctl_n = 1'b0; gate_n = 1'b0; bw_n = 4'b1010; wdata = '1;
        tick();
        ctl_n = 1'b1; gate_n = 1'b1; bw_n = 4'hF;
        ctl_read(8'h30);
        chk_read("R10 lanes 0 and 2", exp);
        addr = 8'h30; ctl_n = 1'b0; gate_n = 1'b1; bw_n = 4'h0; wdata = '0;
        tick();
        ctl_n = 1'b1; bw_n = 4'hF;
        chk_read("R10 gate high no write", exp);
        addr = 8'h30; ctl_n = 1'b0; gw_n = 1'b0; gate_n = 1'b1; bw_n = 4'hF;
        wdata = 36'hA_0F0F_F0F0;
        tick();
        ctl_n = 1'b1; gw_n = 1'b1;
        ctl_read(8'h30);
        chk_read("R9 global write all bits", 36'hA_0F0F_F0F0);
    endtask

    task automatic t_oe();
        oe_n = 1'b1;
        ctl_read(8'h40);
        chk("R11 oe high hiz", W'(rdrive), W'(0));
        oe_n = 1'b0;
        #1;
        chk_read("R11 oe async enable", pat(8'h40));
        addr = 8'h60; ctl_n = 1'b0; gate_n = 1'b0; bw_n = 4'hE; wdata = '0;
        tick();
        ctl_n = 1'b1; gate_n = 1'b1; bw_n = 4'hF;
        chk("R11 no drive in write", W'(rdrive), W'(0));
    endtask

    task automatic t_sleep();
        sleep = 1'b1; addr = 8'h13; ctl_n = 1'b0; gw_n = 1'b0; wdata = '0;
        tick();
        chk("R12 sleep hiz", W'(rdrive), W'(0));
        sleep = 1'b0; ctl_n = 1'b1; gw_n = 1'b1;
        tick();
        chk("R12 idle after sleep", W'(rdrive), W'(0));
        ctl_read(8'h13);
        chk_read("R12 no write in sleep", pat(8'h13));
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #1;
        tick();
        tick();
        t_reset();
        t_ctl_rw();
        t_cpu_start();
        t_cpu_ignored();
        t_cpu_then_write();
        t_deselect();
        t_linear();
        t_interleave();
        t_lanes();
        t_oe();
        t_sleep();
        report();
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
        $finish;
    end

endmodule